// File: doc/BRIEF.md
# Binary Pairwise-Comparison Descriptor

This block turns a keypoint into a 512-bit binary signature. A detector upstream presents a square patch of pixels that has already been smoothed, together with a corner flag and the keypoint's column and row. When the flag is high, the block compares the intensities of a fixed list of point pairs inside the patch. It writes one descriptor bit per pair: the bit is set only when the first point of the pair is brighter than the second.

The pair positions are built into the design as a closed-form table, so no storage is needed and no loading step exists. All 512 comparisons run side by side and their results are registered. A second register holds the finished descriptor and the keypoint coordinates, and it raises a one-cycle strobe. The register keeps its contents between keypoints. A new patch can be accepted on every clock.

Top module: `fdesc_top`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `out_valid` = 0 and `out_desc`, `out_x` and `out_y` all zero.
- R2: Patch pixel k (k = row*15 + col, 0..224) sits at `in_patch[8k+7:8k]`. Pair i (0..511) compares pixel A(i) = (7i + 3) mod 225 with pixel B(i) = (13i + 110) mod 225.
- R3: A pair whose two pixels have equal intensity yields a 0 bit.
- R4: Descriptor bit i is 1 exactly when pixel A(i) is greater than pixel B(i), using an unsigned comparison. Bit i is stored at `out_desc[i]`, so pair 0 is the least significant bit.
- R5: A patch presented with `in_corner` high at clock edge t produces `out_valid` high for exactly one cycle after edge t+1. The outputs then carry that patch's descriptor.
- R6: A cycle with `in_corner` low never produces `out_valid`. Whatever the patch and coordinates hold, `out_desc`, `out_x` and `out_y` keep their previous values.
- R7: Corners on consecutive cycles each produce their own descriptor on consecutive cycles, with no patch lost.
- R8: `out_x` and `out_y` equal the `in_x` and `in_y` presented with the same corner patch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_corner | input | 1 | Centre pixel of the patch is a corner |
| in_x | input | 11 | Keypoint column |
| in_y | input | 11 | Keypoint row |
| in_patch | input | 1800 | Smoothed 15x15 patch, 8 bits per pixel, pixel 0 at the bottom |
| out_valid | output | 1 | One-cycle strobe for a new descriptor |
| out_x | output | 11 | Column of the described keypoint |
| out_y | output | 11 | Row of the described keypoint |
| out_desc | output | 512 | Descriptor, bit i from pair i |

## Verification
The bench presents flat patches in which every pair ties. A design that uses greater-or-equal there would return all ones instead of all zeros. A ramp patch and random patches are used to catch a pair table or a bit order that is off by one: that fault scrambles bits. The same fault also shows up with a single bright pixel placed at A(0), which must set the least significant bit. Idle cycles with a changing patch expose a hold register that loads without a corner, and back-to-back corners expose a pipeline that drops or duplicates a patch or mixes up coordinates.

// File: rtl/fdesc_pkg.sv
package fdesc_pkg;

    localparam int PIX_W   = 8;
    localparam int SIDE    = 15;
    localparam int NPIX    = SIDE * SIDE;
    localparam int NBITS   = 512;
    localparam int COORD_W = 11;

    // closed-form pair table: point A and point B of pair i
    localparam int A_MUL = 7;
    localparam int A_OFF = 3;
    localparam int B_MUL = 13;
    localparam int B_OFF = 110;

    typedef struct packed {
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
    } kp_pos_t;

    typedef struct packed {
        logic    valid;
        kp_pos_t pos;
    } kp_tag_t;

    function automatic int pair_a(input int idx, input int npix);
        return (idx * A_MUL + A_OFF) % npix;
    endfunction

    function automatic int pair_b(input int idx, input int npix);
        return (idx * B_MUL + B_OFF) % npix;
    endfunction

endpackage

// File: rtl/fdesc_sampler.sv
module fdesc_sampler
    import fdesc_pkg::*;
#(
    parameter int PW = PIX_W,
    parameter int NP = NPIX,
    parameter int NB = NBITS
) (
    input  logic [NP*PW-1:0]        patch,
    output logic [NB-1:0][PW-1:0]   pt_a,
    output logic [NB-1:0][PW-1:0]   pt_b
);
    for (genvar g = 0; g < NB; g++) begin : g_pair
        localparam int IA = pair_a(g, NP);
        localparam int IB = pair_b(g, NP);
        assign pt_a[g] = patch[IA*PW +: PW];
        assign pt_b[g] = patch[IB*PW +: PW];
    end
endmodule

// File: rtl/fdesc_cmp_bank.sv
module fdesc_cmp_bank
    import fdesc_pkg::*;
#(
    parameter int PW = PIX_W,
    parameter int NB = NBITS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  kp_tag_t                 tag_in,
    input  logic [NB-1:0][PW-1:0]   pt_a,
    input  logic [NB-1:0][PW-1:0]   pt_b,
    output kp_tag_t                 tag_q,
    output logic [NB-1:0]           bits_q
);
    logic [NB-1:0] gt;

    for (genvar g = 0; g < NB; g++) begin : g_cmp
        assign gt[g] = pt_a[g] > pt_b[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q  <= '0;
            bits_q <= '0;
        end else begin
            tag_q  <= tag_in;
            bits_q <= gt;
        end
    end

    // R4: bit 0 follows the ordering of pair 0 one cycle later
    a_r4_bit0_order: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> bits_q[0] == ($past(pt_a[0]) > $past(pt_b[0])));

    // R3: a tie on pair 0 never sets its bit
    a_r3_tie_zero: assert property (@(posedge clk) disable iff (rst)
        (pt_a[0] == pt_b[0]) |=> !bits_q[0]);
endmodule

// File: rtl/fdesc_out_reg.sv
module fdesc_out_reg
    import fdesc_pkg::*;
#(
    parameter int NB = NBITS
) (
    input  logic            clk,
    input  logic            rst,
    input  kp_tag_t         tag_q,
    input  logic [NB-1:0]   bits_q,
    output logic            out_valid,
    output kp_pos_t         out_pos,
    output logic [NB-1:0]   out_desc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pos   <= '0;
            out_desc  <= '0;
        end else begin
            out_valid <= tag_q.valid;
            if (tag_q.valid) begin
                out_pos  <= tag_q.pos;
                out_desc <= bits_q;
            end
        end
    end

    // R1: reset clears the visible state
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_desc == '0 && out_pos == '0));
endmodule

// File: rtl/fdesc_top.sv
module fdesc_top
    import fdesc_pkg::*;
#(
    parameter int PW = PIX_W,
    parameter int NP = NPIX,
    parameter int NB = NBITS,
    parameter int CW = COORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_corner,
    input  logic [CW-1:0]    in_x,
    input  logic [CW-1:0]    in_y,
    input  logic [NP*PW-1:0] in_patch,
    output logic             out_valid,
    output logic [CW-1:0]    out_x,
    output logic [CW-1:0]    out_y,
    output logic [NB-1:0]    out_desc
);
    logic [NB-1:0][PW-1:0] pt_a, pt_b;
    logic [NB-1:0]         bits_q;
    kp_tag_t               tag_in, tag_q;
    kp_pos_t               pos_q;

    assign tag_in.valid = in_corner;
    assign tag_in.pos.x = in_x;
    assign tag_in.pos.y = in_y;

    fdesc_sampler #(.PW(PW), .NP(NP), .NB(NB)) u_samp (
        .patch (in_patch),
        .pt_a  (pt_a),
        .pt_b  (pt_b)
    );

    fdesc_cmp_bank #(.PW(PW), .NB(NB)) u_cmp (
        .clk    (clk),
        .rst    (rst),
        .tag_in (tag_in),
        .pt_a   (pt_a),
        .pt_b   (pt_b),
        .tag_q  (tag_q),
        .bits_q (bits_q)
    );

    fdesc_out_reg #(.NB(NB)) u_out (
        .clk       (clk),
        .rst       (rst),
        .tag_q     (tag_q),
        .bits_q    (bits_q),
        .out_valid (out_valid),
        .out_pos   (pos_q),
        .out_desc  (out_desc)
    );

    assign out_x = pos_q.x;
    assign out_y = pos_q.y;

    // R5: a corner is reported two edges later
    a_r5_corner_reported: assert property (@(posedge clk) disable iff (rst)
        in_corner |=> ##1 out_valid);

    // R6: a non-corner cycle never strobes nor disturbs the outputs
    a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_corner |=> ##1 (!out_valid && $stable(out_desc) && $stable(out_x) && $stable(out_y)));

    // R8: coordinates travel with the corner
    a_r8_coords_follow: assert property (@(posedge clk) disable iff (rst)
        in_corner |=> ##1 (out_x == $past(in_x, 2) && out_y == $past(in_y, 2)));
endmodule

// File: tb/tb_fdesc_top.sv
module tb_fdesc_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPX = 225;
    localparam int NB  = 512;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_corner;
    logic [10:0]      in_x, in_y;
    logic [NPX*8-1:0] in_patch;
    logic             out_valid;
    logic [10:0]      out_x, out_y;
    logic [NB-1:0]    out_desc;

    fdesc_top dut (
        .clk(clk), .rst(rst), .in_corner(in_corner), .in_x(in_x), .in_y(in_y),
        .in_patch(in_patch), .out_valid(out_valid), .out_x(out_x), .out_y(out_y),
        .out_desc(out_desc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [7:0] pix [NPX];

    // reference model: stage one then visible output
    logic          m1_v;
    logic [NB-1:0] m1_d;
    logic [10:0]   m1_x, m1_y;
    logic          m_v;
    logic [NB-1:0] m_d;
    logic [10:0]   m_x, m_y;

    function automatic logic [NB-1:0] ref_desc();
        logic [NB-1:0] d;
        for (int i = 0; i < NB; i++) begin
            int a = (7*i + 3) % NPX;
            int b = (13*i + 110) % NPX;
            d[i] = pix[a] > pix[b];
        end
        return d;
    endfunction

    task automatic pack_patch();
        for (int k = 0; k < NPX; k++) in_patch[k*8 +: 8] = pix[k];
    endtask

    task automatic chk(input string req, input logic cond, input string what,
                       input logic [NB-1:0] got, input logic [NB-1:0] exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
        end
    endtask

    task automatic compare_all(input string req);
        chk(req, out_valid == m_v, "valid", NB'(out_valid), NB'(m_v));
        chk(req, out_desc == m_d, "desc", out_desc, m_d);
        chk({req, "/R8"}, out_x == m_x && out_y == m_y, "coords",
            NB'({out_x, out_y}), NB'({m_x, m_y}));
    endtask

    // called at a negedge: apply inputs, advance model, check at next negedge
    task automatic step(input logic corner, input logic [10:0] x, input logic [10:0] y,
                        input string req);
        pack_patch();
        in_corner = corner; in_x = x; in_y = y;
        m_v = m1_v;
        if (m1_v) begin m_d = m1_d; m_x = m1_x; m_y = m1_y; end
        m1_v = corner; m1_d = ref_desc(); m1_x = x; m1_y = y;
        @(negedge clk);
        compare_all(req);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_corner = 1'b0; in_x = '0; in_y = '0;
        for (int k = 0; k < NPX; k++) pix[k] = 8'(k * 37 + 5);
        pack_patch();
        in_corner = 1'b1;                 // corner held during reset must be dropped
        m1_v = 0; m1_d = '0; m1_x = '0; m1_y = '0;
        m_v = 0; m_d = '0; m_x = '0; m_y = '0;
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst = 1'b0;
        in_corner = 1'b0;

        // R2 / R4: ramp patch
        for (int k = 0; k < NPX; k++) pix[k] = 8'(k);
        step(1, 11'd20, 11'd30, "R2");
        step(0, 11'd0, 11'd0, "R5");
        step(0, 11'd0, 11'd0, "R5");
        chk("R4", out_desc[0] == (8'd3 > 8'd110), "ramp bit0", NB'(out_desc[0]), NB'(0));

        // R4: single bright pixel at A(0)=3 sets the LSB
        for (int k = 0; k < NPX; k++) pix[k] = 8'd10;
        pix[3] = 8'd200;
        step(1, 11'd7, 11'd9, "R4");
        step(0, 11'd0, 11'd0, "R4");
        step(0, 11'd0, 11'd0, "R4");
        chk("R4", out_desc[0] == 1'b1, "lsb from pair 0", NB'(out_desc[0]), NB'(1));

        // R3: flat patch after a nonzero descriptor -> all zeros
        for (int k = 0; k < NPX; k++) pix[k] = 8'd77;
        step(1, 11'd100, 11'd200, "R3");
        step(0, 11'd0, 11'd0, "R3");
        step(0, 11'd0, 11'd0, "R3");
        chk("R3", out_desc == '0, "flat patch", out_desc, '0);

        // R6: idle cycles with changing data
        for (int n = 0; n < 6; n++) begin
            for (int k = 0; k < NPX; k++) pix[k] = 8'($urandom);
            step(0, 11'($urandom), 11'($urandom), "R6");
        end

        // R7: back-to-back random corners
        for (int n = 0; n < 12; n++) begin
            for (int k = 0; k < NPX; k++) pix[k] = 8'($urandom);
            step(1, 11'(n * 13 + 1), 11'(2047 - n), "R7");
        end
        // R2: mixed random traffic
        for (int n = 0; n < 40; n++) begin
            for (int k = 0; k < NPX; k++) pix[k] = 8'($urandom_range(0, 3));
            step(1'($urandom_range(0, 1)), 11'($urandom), 11'($urandom), "R2");
        end
        for (int n = 0; n < 3; n++) step(0, 11'd0, 11'd0, "R6");

        // R1: reset mid-stream clears outputs
        rst = 1'b1;
        m1_v = 0; m1_d = '0; m1_x = '0; m1_y = '0;
        m_v = 0; m_d = '0; m_x = '0; m_y = '0;
        repeat (2) @(negedge clk);
        compare_all("R1");
        rst = 1'b0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule